// File: doc/BRIEF.md
# GPIO Edge Event Detector with SMI Output

This block watches a small group of general-purpose pins and turns edge events on them into sticky status bits. Every pin can be programmed as an input or as an output. Pins that are inputs pass through a two-flop synchronizer. After that, either the rising edge alone or both edges are detected, as chosen per pin. Each detected event sets two status bits at once: one in a power-management status register and one in an SMI status register.

The enabled SMI status bits are ORed together into a single group interrupt. A global enable bit gates this group interrupt before it reaches an active-low pad output. The pad can be driven as open-drain or as push-pull. In open-drain mode the inactive pad is released. In push-pull mode the inactive pad is driven high. A second group output shows the enabled power-management status bits.

Host software uses a small register port. It reads the status bits and clears them by writing a one to each bit. It also sets the enables, the pin directions, the output data, the edge modes and the pad drive type.

Top module: `gpio_smi_evt`

## Requirements
- R1: After reset, the pins selected by parameter DIR_RST (default 4'b0011) are inputs and the others are outputs driven low (pin_oe=1, pin_out=0). Both status registers read DIR_RST, because every input pin has its status bits set at reset. All enables, edge modes and the control register read 0.
- R2: With the edge-mode bit of a pin at 0 (address 6), only a low-to-high input transition sets that pin's bit in the PME status register (address 0) and in the SMI status register (address 1). A high-to-low transition sets neither.
- R3: With the edge-mode bit of a pin at 1, both transitions set the pin's PME and SMI status bits.
- R4: A pin whose direction bit (address 4, 1 = input) is 0 never sets a status bit, whatever its pad does.
- R5: Writing a 1 to a bit of a status register clears that bit. Writing a 0 leaves it unchanged. Each status register is cleared only by writes to its own address.
- R6: When an event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: The SMI group signal is active only when bit 7 of address 3 (the global enable) is 1 and at least one SMI status bit is set whose enable bit (address 3, bits [NPIN-1:0]) is also 1.
- R8: In open-drain mode (address 7 bit 0 = 0), the pad is released when the group signal is inactive (smi_n_oe=0) and driven low when it is active. In push-pull mode (bit 0 = 1), smi_n_oe=1 always and smi_n_o is low exactly when the group signal is active.
- R9: pme_o is 1 exactly when some PME status bit and its enable bit (address 2) are both 1.
- R10: An input transition sets its status bits on the third rising clock edge after it occurs.
- R11: Each output pin drives the matching bit of the output data register (address 5), with pin_oe equal to the inverse of its direction bit. Registers read back what was written, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on/hard reset |
| pin_in | input | NPIN | Pad input levels (asynchronous) |
| pin_out | output | NPIN | Pad output data |
| pin_oe | output | NPIN | Pad output enable (1 = driven) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| pme_o | output | 1 | Group power-management event, active high |
| smi_n_o | output | 1 | SMI pad data, active low |
| smi_n_oe | output | 1 | SMI pad output enable |

## Verification
The bench walks every pin through both edge directions in both edge modes and in both directions. A detector that ignored the mode, or let output pins post events, would leave the wrong status bits set. It sweeps every status pattern against every enable mask, both global-enable values and both drive types. This catches a dropped global gate, a wrong AND-OR merge, or an open-drain pad that drives high. It also lands a clearing write in the exact cycle of an event and checks the three-edge latency. A design where clear beat set, or with an extra or missing synchronizer stage, would be seen one cycle off.

// File: rtl/gpio_smi_evt.sv
module gpio_smi_evt #(
  parameter int NPIN = 4,
  parameter int DW = 8,
  parameter logic [NPIN-1:0] DIR_RST = NPIN'(3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            pme_o,
  output logic            smi_n_o,
  output logic            smi_n_oe
);
  localparam int GEN = DW - 1;
  localparam logic [2:0] A_PSTS = 3'd0, A_SSTS = 3'd1, A_PEN = 3'd2, A_SEN = 3'd3,
                         A_DIR = 3'd4, A_DOUT = 3'd5, A_MODE = 3'd6, A_CTL = 3'd7;

  logic [NPIN-1:0] s1, s2, prev;
  logic [1:0]      warm;
  logic [NPIN-1:0] pme_sts, smi_sts, pme_en, smi_en, dir, dout, both;
  logic            gen_en, push_pull;
  logic [NPIN-1:0] evt, clr_p, clr_s, wd;
  logic            smi_act;

  assign wd    = reg_wdata[NPIN-1:0];
  assign evt   = (warm == 2'd3) ? dir & ((both & (s2 ^ prev)) | (~both & s2 & ~prev)) : '0;
  assign clr_p = (reg_wr && reg_addr == A_PSTS) ? wd : '0;
  assign clr_s = (reg_wr && reg_addr == A_SSTS) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prev <= '0;
      warm <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      prev <= s2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_sts <= DIR_RST;
      smi_sts <= DIR_RST;
    end else begin
      pme_sts <= (pme_sts & ~clr_p) | evt;
      smi_sts <= (smi_sts & ~clr_s) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_en <= '0;
      smi_en <= '0;
      gen_en <= 1'b0;
      dir <= DIR_RST;
      dout <= '0;
      both <= '0;
      push_pull <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_PEN:  pme_en <= wd;
        A_SEN:  begin smi_en <= wd; gen_en <= reg_wdata[GEN]; end
        A_DIR:  dir <= wd;
        A_DOUT: dout <= wd;
        A_MODE: both <= wd;
        A_CTL:  push_pull <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PSTS: reg_rdata[NPIN-1:0] = pme_sts;
      A_SSTS: reg_rdata[NPIN-1:0] = smi_sts;
      A_PEN:  reg_rdata[NPIN-1:0] = pme_en;
      A_SEN:  begin reg_rdata[NPIN-1:0] = smi_en; reg_rdata[GEN] = gen_en; end
      A_DIR:  reg_rdata[NPIN-1:0] = dir;
      A_DOUT: reg_rdata[NPIN-1:0] = dout;
      A_MODE: reg_rdata[NPIN-1:0] = both;
      default: reg_rdata[0] = push_pull;
    endcase
  end

  assign pin_out  = dout;
  assign pin_oe   = ~dir;
  assign pme_o    = |(pme_sts & pme_en);
  assign smi_act  = gen_en & (|(smi_sts & smi_en));
  assign smi_n_o  = ~smi_act;
  assign smi_n_oe = push_pull | smi_act;
endmodule

module gpio_smi_evt_chk #(
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [2:0]      reg_addr,
  input logic [NPIN-1:0] smi_sts,
  input logic [NPIN-1:0] smi_en,
  input logic            gen_en,
  input logic            push_pull,
  input logic [NPIN-1:0] dir,
  input logic            smi_n_o,
  input logic            smi_n_oe
);
  // R7
  smi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en || (smi_sts & smi_en) == '0) |-> (push_pull ? (smi_n_oe && smi_n_o) : !smi_n_oe));
  // R8
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_pull |-> (!smi_n_oe || !smi_n_o));
  // R5
  sticky_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd1) |=> ((smi_sts & $past(smi_sts)) == $past(smi_sts)));
  // R4
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((smi_sts & ~$past(smi_sts) & ~$past(dir)) == '0));
endmodule

bind gpio_smi_evt gpio_smi_evt_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .smi_sts(smi_sts), .smi_en(smi_en), .gen_en(gen_en), .push_pull(push_pull),
  .dir(dir), .smi_n_o(smi_n_o), .smi_n_oe(smi_n_oe)
);

// File: tb/gpio_smi_evt_test.sv
`timescale 1ns/1ps
module gpio_smi_evt_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic pme_o, smi_n_o, smi_n_oe;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  gpio_smi_evt uut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pme_o(pme_o), .smi_n_o(smi_n_o), .smi_n_oe(smi_n_oe));

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_all();
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd0, v); check("R1 pme_sts", v, 8'h03);
    rd(3'd1, v); check("R1 smi_sts", v, 8'h03);
    rd(3'd4, v); check("R1 dir", v, 8'h03);
    for (int a = 2; a < 8; a++) if (a != 4) begin
      rd(a[2:0], v); check($sformatf("R1 reg%0d", a), v, 8'h00);
    end
    check("R1 pin_oe", {4'h0, pin_oe}, 8'h0C);
    check("R1 pin_out", {4'h0, pin_out}, 8'h00);
    check("R1 smi_oe", {7'h0, smi_n_oe}, 8'h00);

    // R11 readback and output pins
    wr(3'd4, 8'hF5); rd(3'd4, v); check("R11 dir rb", v, 8'h05);
    check("R11 pin_oe", {4'h0, pin_oe}, 8'h0A);
    wr(3'd5, 8'hA6); rd(3'd5, v); check("R11 dout rb", v, 8'h06);
    check("R11 pin_out", {4'h0, pin_out}, 8'h06);
    wr(3'd3, 8'hFF); rd(3'd3, v); check("R11 smi_en rb", v, 8'h8F);
    wr(3'd7, 8'hFF); rd(3'd7, v); check("R11 ctl rb", v, 8'h01);
    wr(3'd3, 8'h00); wr(3'd7, 8'h00); wr(3'd5, 8'h00);

    // R2 rising-only mode, R5 write-one-to-clear
    wr(3'd4, 8'h0F); wr(3'd6, 8'h00); settle(); clr_all();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); pin_in[i] = 1'b1; settle();
      rd(3'd0, v); check($sformatf("R2 rise pme p%0d", i), v, 8'(1 << i));
      rd(3'd1, v); check($sformatf("R2 rise smi p%0d", i), v, 8'(1 << i));
      wr(3'd1, 8'h00); rd(3'd1, v); check("R5 zero write keeps", v, 8'(1 << i));
      wr(3'd1, 8'hFF); rd(3'd1, v); check("R5 smi cleared", v, 8'h00);
      rd(3'd0, v); check("R5 pme untouched", v, 8'(1 << i));
      wr(3'd0, 8'(1 << i)); rd(3'd0, v); check("R5 pme cleared", v, 8'h00);
      @(negedge clk); pin_in[i] = 1'b0; settle();
      rd(3'd0, v); check($sformatf("R2 fall pme p%0d", i), v, 8'h00);
      rd(3'd1, v); check($sformatf("R2 fall smi p%0d", i), v, 8'h00);
    end

    // R3 either-edge mode
    wr(3'd6, 8'h0F);
    for (int i = 0; i < N; i++) begin
      for (int e = 1; e >= 0; e--) begin
        @(negedge clk); pin_in[i] = e[0]; settle();
        rd(3'd0, v); check($sformatf("R3 pme p%0d e%0d", i, e), v, 8'(1 << i));
        rd(3'd1, v); check($sformatf("R3 smi p%0d e%0d", i, e), v, 8'(1 << i));
        clr_all();
      end
    end

    // R4 output pins ignored
    wr(3'd4, 8'h00); clr_all();
    for (int m = 0; m < 2; m++) begin
      wr(3'd6, m[0] ? 8'h0F : 8'h00);
      @(negedge clk); pin_in = 4'hF; settle();
      @(negedge clk); pin_in = 4'h0; settle();
      rd(3'd0, v); check("R4 pme quiet", v, 8'h00);
      rd(3'd1, v); check("R4 smi quiet", v, 8'h00);
    end

    // R10 latency
    wr(3'd4, 8'h0F); wr(3'd6, 8'h00); settle(); clr_all();
    @(negedge clk); pin_in[2] = 1'b1;
    @(negedge clk); @(negedge clk); #0.5;
    reg_addr = 3'd1; #0.5; check("R10 not yet", reg_rdata, 8'h00);
    @(negedge clk); #0.5; check("R10 third edge", reg_rdata, 8'h04);
    clr_all(); @(negedge clk); pin_in[2] = 1'b0; settle();

    // R6 set wins over clear
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'hFF;
    @(negedge clk); reg_wr = 0;
    rd(3'd1, v); check("R6 set wins", v, 8'h02);
    clr_all(); @(negedge clk); pin_in[1] = 1'b0; settle();

    // R7 R8 R9 sweep
    wr(3'd6, 8'h0F);
    for (int s = 0; s < 16; s++) begin
      clr_all();
      @(negedge clk); pin_in = ~pin_in; settle();
      wr(3'd0, 8'(~s & 4'hF)); wr(3'd1, 8'(~s & 4'hF));
      rd(3'd1, v); check("R5 pattern", v, 8'(s));
      for (int en = 0; en < 16; en++) begin
        wr(3'd2, 8'(en));
        check("R9 pme_o", {7'h0, pme_o}, {7'h0, ((s & en) != 0)});
        for (int g = 0; g < 2; g++) begin
          wr(3'd3, 8'(en | (g << 7)));
          for (int pp = 0; pp < 2; pp++) begin
            logic act;
            wr(3'd7, 8'(pp));
            act = (g == 1) && ((s & en) != 0);
            if (pp == 1) begin
              check("R8 pp oe", {7'h0, smi_n_oe}, 8'h01);
              check("R7 pp level", {7'h0, smi_n_o}, {7'h0, !act});
            end else begin
              check("R8 od oe", {7'h0, smi_n_oe}, {7'h0, act});
              if (act) check("R7 od low", {7'h0, smi_n_o}, 8'h00);
            end
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule